// File: doc/BRIEF.md
# Oversampled Serial Byte Receiver

This block takes one asynchronous serial line and turns each character on it into a parallel byte. The character format is fixed: one low start bit, eight data bits sent least significant bit first, one high stop bit, and no parity. The block runs from a fast system clock and divides that clock down to a tick that runs at sixteen times the bit rate. With the default divisor of 326 and a 50 MHz clock, the bit rate is close to 9600 bit/s.

The receiver synchronizes the line through two flops. It waits for a high-to-low transition on the line. It then requires eight low ticks in a row before it accepts a start bit, which places the sampling phase near the middle of the bit. After that it samples one bit every sixteen ticks. A completed byte is copied into an output register, and a one-cycle valid strobe is raised with it. If the stop bit reads low, the byte is discarded and a one-cycle framing-error strobe is raised instead.

The byte output is a stream with no back-pressure. A serial line cannot be paused, so there is no ready input. The consumer must take `out_data` in the cycle in which `out_valid` is high. The value stays in the register until the next good byte arrives.

Top module: `serial_byte_rx`

## Requirements
- R1: A free-running divider raises an internal tick once every DIV system clocks (default 326); all bit timing counts these ticks, 16 per bit period.
- R2: Reception is armed only by a high-to-low transition of the synchronized line; a line that stays low after a frame starts no new frame until it has gone high and fallen again.
- R3: After the falling edge, the line must read low on 8 consecutive ticks to confirm a start bit; a high reading before that returns the receiver to idle with no output.
- R4: After confirmation, each of the 8 data bits is sampled 16 ticks after the previous sample, the first received bit lands in `out_data[0]` and the last in `out_data[7]`.
- R5: `out_data` changes only in a cycle where `out_valid` is high and otherwise holds the last good byte.
- R6: Each frame with a high stop bit yields exactly one `out_valid` pulse of exactly one clock.
- R7: A frame whose stop bit samples low raises `frame_err` for exactly one clock, produces no `out_valid`, and leaves `out_data` unchanged; both strobes are never high together.
- R8: While `rst_n` is low and right after it, `out_valid` and `frame_err` are 0 and `out_data` is 8'h00, and a frame cut off by reset produces no output.
- R9: Two frames sent back to back, with only a single stop bit between them, are both received in order.
- R10: The control state is one-hot at all times, with exactly one of idle, start-check, data and stop active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_line | input | 1 | Asynchronous serial input, idles high |
| out_valid | output | 1 | One-clock strobe: `out_data` holds a newly received byte |
| out_data | output | 8 | Last correctly framed byte |
| frame_err | output | 1 | One-clock strobe: stop bit sampled low |

## Verification
The assertions take for granted that `rx_line` carries characters at a bit period of 16 × DIV clocks. They also assume that any low pulse that is not a start bit is shorter than eight ticks. They make no assumption about the phase between line edges and ticks. The stimulus drives every bit for exactly 16 × DIV clocks, with a small DIV override. Spurious pulses are kept to eight clocks, which is at most three ticks. Each start edge is launched from the falling clock edge at an arbitrary point in the tick cycle.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  typedef enum logic [3:0] {
    ST_IDLE = 4'b0001,
    ST_QUAL = 4'b0010,
    ST_BITS = 4'b0100,
    ST_STOP = 4'b1000
  } rx_state_e;
endpackage

// File: rtl/rx_tick_div.sv
module rx_tick_div #(
  parameter int DIV = 326
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  assign tick = (cnt_q == LAST);
endmodule

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] sr_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sr_q[0] <= 1'b1;
          else        sr_q[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sr_q[i] <= 1'b1;
          else        sr_q[i] <= sr_q[i-1];
        end
      end
    end
  endgenerate

  assign dout = sr_q[STAGES-1];
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
  import serial_rx_pkg::*;
#(
  parameter int OVS   = 16,
  parameter int QUAL  = 8,
  parameter int NBITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             rx_s,
  output rx_state_e        state,
  output logic [NBITS-1:0] shreg,
  output logic             take,
  output logic             bad
);
  localparam int TW = $clog2(OVS);
  localparam int BW = $clog2(NBITS + 1);
  localparam logic [TW-1:0] QUAL_LAST = TW'(QUAL - 1);
  localparam logic [TW-1:0] OVS_LAST  = TW'(OVS - 1);
  localparam logic [BW-1:0] BIT_LAST  = BW'(NBITS - 1);

  rx_state_e        state_q, state_d;
  logic [TW-1:0]    tcnt_q, tcnt_d;
  logic [BW-1:0]    bcnt_q, bcnt_d;
  logic [NBITS-1:0] sh_q, sh_d;
  logic             prev_q;
  logic             fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= rx_s;
  end

  assign fall = prev_q & ~rx_s;

  always_comb begin
    state_d = state_q;
    tcnt_d  = tcnt_q;
    bcnt_d  = bcnt_q;
    sh_d    = sh_q;
    take    = 1'b0;
    bad     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (fall) begin
          state_d = ST_QUAL;
          tcnt_d  = '0;
        end
      end
      ST_QUAL: begin
        if (tick) begin
          if (rx_s) begin
            state_d = ST_IDLE;
          end else if (tcnt_q == QUAL_LAST) begin
            state_d = ST_BITS;
            tcnt_d  = '0;
            bcnt_d  = '0;
          end else begin
            tcnt_d = tcnt_q + 1'b1;
          end
        end
      end
      ST_BITS: begin
        if (tick) begin
          if (tcnt_q == OVS_LAST) begin
            tcnt_d = '0;
            sh_d   = {rx_s, sh_q[NBITS-1:1]};
            if (bcnt_q == BIT_LAST) state_d = ST_STOP;
            else                    bcnt_d  = bcnt_q + 1'b1;
          end else begin
            tcnt_d = tcnt_q + 1'b1;
          end
        end
      end
      ST_STOP: begin
        if (tick) begin
          if (tcnt_q == OVS_LAST) begin
            state_d = ST_IDLE;
            take    = rx_s;
            bad     = ~rx_s;
          end else begin
            tcnt_d = tcnt_q + 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tcnt_q  <= '0;
      bcnt_q  <= '0;
      sh_q    <= '0;
    end else begin
      state_q <= state_d;
      tcnt_q  <= tcnt_d;
      bcnt_q  <= bcnt_d;
      sh_q    <= sh_d;
    end
  end

  assign state = state_q;
  assign shreg = sh_q;
endmodule

// File: rtl/rx_out_latch.sv
module rx_out_latch #(
  parameter int NBITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             bad,
  input  logic [NBITS-1:0] shreg,
  output logic             out_valid,
  output logic [NBITS-1:0] out_data,
  output logic             frame_err
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      frame_err <= 1'b0;
    end else begin
      out_valid <= take;
      frame_err <= bad;
      if (take) out_data <= shreg;
    end
  end
endmodule

// File: rtl/serial_byte_rx.sv
module serial_byte_rx
  import serial_rx_pkg::*;
#(
  parameter int DIV         = 326,
  parameter int OVS         = 16,
  parameter int QUAL        = 8,
  parameter int NBITS       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_line,
  output logic             out_valid,
  output logic [NBITS-1:0] out_data,
  output logic             frame_err
);
  logic             tick;
  logic             rx_s;
  rx_state_e        fsm_state;
  logic [NBITS-1:0] shreg;
  logic             take;
  logic             bad;

  rx_tick_div #(.DIV(DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rx_line), .dout(rx_s)
  );

  rx_frame_fsm #(.OVS(OVS), .QUAL(QUAL), .NBITS(NBITS)) u_fsm (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rx_s(rx_s),
    .state(fsm_state), .shreg(shreg), .take(take), .bad(bad)
  );

  rx_out_latch #(.NBITS(NBITS)) u_lat (
    .clk(clk), .rst_n(rst_n), .take(take), .bad(bad), .shreg(shreg),
    .out_valid(out_valid), .out_data(out_data), .frame_err(frame_err)
  );
endmodule

// File: rtl/serial_byte_rx_chk.sv
module serial_byte_rx_chk
  import serial_rx_pkg::*;
#(
  parameter int NBITS = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             rx_s,
  input logic [3:0]       state,
  input logic             out_valid,
  input logic [NBITS-1:0] out_data,
  input logic             frame_err
);
  a_r1_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  a_r10_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(state) == 1);

  a_r3_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_QUAL && tick && rx_s) |=> (state == ST_IDLE));

  a_r5_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_data));

  a_r6_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  a_r7_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> !frame_err);

  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && frame_err));
endmodule

bind serial_byte_rx serial_byte_rx_chk #(.NBITS(NBITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .rx_s(rx_s), .state(fsm_state),
  .out_valid(out_valid), .out_data(out_data), .frame_err(frame_err)
);

// File: tb/serial_byte_rx_bench.sv
module serial_byte_rx_bench;
  localparam int DIV = 4;
  localparam int BIT = 16 * DIV;
  localparam int NV  = 8;
  // {stop bit, data byte}
  localparam logic [8:0] VECS [NV] = '{
    {1'b1, 8'h55}, {1'b1, 8'h00}, {1'b1, 8'hFF}, {1'b1, 8'hA3},
    {1'b0, 8'h5A}, {1'b1, 8'h01}, {1'b1, 8'h80}, {1'b0, 8'hC3}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx = 1'b1;
  logic out_valid, frame_err;
  logic [7:0] out_data;

  int checks = 0, fails = 0, cyc = 0;
  int vcnt = 0, ecnt = 0;
  logic [7:0] last = 8'h00, prevlast = 8'h00;
  bit was_valid = 0, width_bad = 0;

  always #10 clk = ~clk;

  serial_byte_rx #(.DIV(DIV)) u_serial_byte_rx (
    .clk(clk), .rst_n(rst_n), .rx_line(rx),
    .out_valid(out_valid), .out_data(out_data), .frame_err(frame_err)
  );

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      vcnt++;
      prevlast = last;
      last = out_data;
      if (was_valid) width_bad = 1;
    end
    was_valid = out_valid;
    if (rst_n && frame_err) ecnt++;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung, act=%0d exp<150000 cycles", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic hold(input logic v, input int n);
    rx = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b, input logic stop);
    hold(1'b0, BIT);
    for (int k = 0; k < 8; k++) hold(b[k], BIT);
    hold(stop, BIT);
    rx = 1'b1;
  endtask

  int v0, e0;
  logic [7:0] good;

  initial begin
    repeat (5) @(negedge clk);
    // R8: reset state
    chk(out_valid == 1'b0, "R8 reset out_valid", out_valid, 0);
    chk(frame_err == 1'b0, "R8 reset frame_err", frame_err, 0);
    chk(out_data == 8'h00, "R8 reset out_data", out_data, 0);
    rst_n = 1'b1;
    hold(1'b1, 3 * BIT);

    good = 8'h00;
    for (int i = 0; i < NV; i++) begin
      v0 = vcnt; e0 = ecnt;
      send(VECS[i][7:0], VECS[i][8]);
      hold(1'b1, 2 * BIT);
      if (VECS[i][8]) begin
        good = VECS[i][7:0];
        // R1/R10: decoding at 16*DIV clocks per bit walks all four states
        chk(vcnt == v0 + 1, "R6 one valid per good frame", vcnt - v0, 1);
        chk(last == good, "R4 data bits LSB first (R1 tick timing)", last, good);
        chk(ecnt == e0, "R7 no frame_err on good stop", ecnt - e0, 0);
      end else begin
        chk(ecnt == e0 + 1, "R7 frame_err on low stop", ecnt - e0, 1);
        chk(vcnt == v0, "R7 no valid on low stop", vcnt - v0, 0);
        chk(out_data == good, "R5 out_data held after bad frame", out_data, good);
      end
    end

    // R3: short low pulse is rejected
    v0 = vcnt; e0 = ecnt;
    hold(1'b0, 8);
    hold(1'b1, 12 * BIT);
    chk(vcnt == v0 && ecnt == e0, "R3 glitch gives no output", vcnt - v0 + ecnt - e0, 0);
    chk(out_data == good, "R3 glitch leaves out_data", out_data, good);
    send(8'h96, 1'b1);
    hold(1'b1, 2 * BIT);
    chk(last == 8'h96, "R3 byte after glitch", last, 8'h96);

    // R9: back to back frames
    v0 = vcnt;
    send(8'h12, 1'b1);
    send(8'h34, 1'b1);
    hold(1'b1, 2 * BIT);
    chk(vcnt == v0 + 2, "R9 two frames seen", vcnt - v0, 2);
    chk(prevlast == 8'h12, "R9 first frame", prevlast, 8'h12);
    chk(last == 8'h34, "R9 second frame", last, 8'h34);

    // R2: line stuck low after a bad frame does not re-arm
    v0 = vcnt; e0 = ecnt;
    send(8'h77, 1'b0);
    hold(1'b0, 4 * BIT);
    chk(ecnt == e0 + 1, "R2 single frame_err while held low", ecnt - e0, 1);
    chk(vcnt == v0, "R2 no valid while held low", vcnt - v0, 0);
    hold(1'b1, 2 * BIT);
    chk(ecnt == e0 + 1 && vcnt == v0, "R2 nothing on release", ecnt - e0 + vcnt - v0, 1);
    send(8'h3C, 1'b1);
    hold(1'b1, 2 * BIT);
    chk(last == 8'h3C, "R2 byte after release", last, 8'h3C);

    // R6: pulse width
    chk(width_bad == 0, "R6 valid one clock wide", width_bad, 0);

    // R8: reset mid frame
    v0 = vcnt; e0 = ecnt;
    hold(1'b0, BIT);
    hold(1'b1, BIT);
    hold(1'b0, 2 * BIT);
    rst_n = 1'b0;
    rx = 1'b1;
    repeat (3) @(negedge clk);
    chk(out_data == 8'h00, "R8 out_data cleared", out_data, 0);
    chk(out_valid == 1'b0 && frame_err == 1'b0, "R8 strobes low in reset", out_valid + frame_err, 0);
    rst_n = 1'b1;
    hold(1'b1, 12 * BIT);
    chk(vcnt == v0 && ecnt == e0, "R8 aborted frame gives no output", vcnt - v0 + ecnt - e0, 0);
    send(8'hE7, 1'b1);
    hold(1'b1, 2 * BIT);
    chk(last == 8'hE7 && vcnt == v0 + 1, "R8 reception after reset", last, 8'hE7);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule